// File: doc/BRIEF.md
# Status Queue Space Attention Controller

This block watches the write side of one channel's circular status queue in host memory. Each time the descriptor writer stores a status entry, the write index steps forward one slot and wraps at the queue depth. When the entry just stored sits in the slot right before the host-programmed limit, a sticky attention flag goes up. The channel then stops taking new work until the host moves the limit forward and clears the flag with a write-one-to-clear.

A parameter picks one of two flavours. The receive flavour has no pipeline slack. The tripping entry is marked as special in the same cycle it is written, and any later write attempt is dropped. The transmit-request flavour has no special marker. It still accepts up to two confirmation entries after the flag goes up, because upstream pipelining can already have them in flight. Its stall output also stays high while a companion user-request attention bit is set.

The flag comes out of reset already set, so a channel never runs before the host has programmed a limit and cleared the flag.

Top module: `status_slot_guard`

## Requirements
- R1: After reset, attn and stall are 1, wr_ptr is 0, last_tag is 0, and the limit register holds 0.
- R2: An accepted entry write moves wr_ptr from k to (k+1) mod DEPTH in the next cycle, so DEPTH-1 wraps to 0.
- R3: An accepted write made while (wr_ptr+1) mod DEPTH equals the limit makes attn 1 in the next cycle.
- R4: Once attn is 1 it stays 1 until attn_clr is sampled high. A clear with no new set condition makes attn 0 in the next cycle.
- R5: If attn_clr and a set condition fall in the same cycle, attn is 1 in the next cycle.
- R6: In the receive flavour (VARIANT = SSG_RX), stall equals attn, and entry writes made while attn is 1 are ignored, so wr_ptr does not change.
- R7: In the receive flavour, last_tag is 1 in exactly the cycle of the write that meets the R3 condition, and 0 in all other cycles.
- R8: In the transmit flavour (VARIANT = SSG_TX), exactly TX_SLACK (default 2) writes are accepted after attn rises, and any further writes are ignored until attn clears. Writes made while attn is 1 from reset are never accepted.
- R9: In the transmit flavour, stall equals attn OR usr_attn, and last_tag is always 0.
- R10: limit_wr loads limit_data into the limit register at the clock edge. A write in the same cycle is compared against the old limit, and later writes are compared against the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| limit_wr | input | 1 | Host load strobe for the limit register |
| limit_data | input | PW | New limit slot index |
| entry_wr | input | 1 | Descriptor writer stores one status entry |
| attn_clr | input | 1 | Host write-one-to-clear of the attention flag |
| usr_attn | input | 1 | Companion user-request attention level (transmit flavour only) |
| attn | output | 1 | Sticky out-of-status-space attention flag |
| stall | output | 1 | Halts new copying or request processing on the channel |
| last_tag | output | 1 | Marks the entry being written as the special final one |
| wr_ptr | output | PW | Current write slot index |

## Verification
One receive instance and one transmit instance, both with an eight-slot queue, get the same stimulus. The first pattern sweeps every limit value, then keeps writing after the trip. This shows whether the trip falls on the next-to-last slot and not one early or one late, and how many extra writes each flavour lets through. The second sweep holds the clear high on every cycle. It separates a set that correctly wins over a coincident clear from a clear that wrongly wins. The third pattern interleaves writes, clears, limit loads and usr_attn changes. It tests the old-versus-new limit ordering within one cycle and shows whether the companion bit feeds only the transmit stall.

// File: rtl/ssg_pkg.sv
package ssg_pkg;

   typedef enum logic [0:0] {
      SSG_RX = 1'b0,
      SSG_TX = 1'b1
   } ssg_variant_e;

endpackage

// File: rtl/ssg_limit_reg.sv
module ssg_limit_reg #(
   parameter int PW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [PW-1:0] load_val,
   output logic [PW-1:0] limit
);

   logic [PW-1:0] limit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         limit_q <= '0;
      else if (load)
         limit_q <= load_val;
   end

   assign limit = limit_q;

endmodule

// File: rtl/ssg_wr_ptr.sv
module ssg_wr_ptr #(
   parameter int DEPTH = 8,
   parameter int PW    = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          advance,
   input  logic [PW-1:0] limit,
   output logic [PW-1:0] ptr,
   output logic          hit
);

   localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);

   logic [PW-1:0] ptr_q;
   logic [PW-1:0] ptr_nxt;

   // index of the slot after the current one, wrapping at the depth
   assign ptr_nxt = (ptr_q == LAST_IDX) ? '0 : ptr_q + 1'b1;

   // the slot being written is the one right before the limit
   assign hit = (ptr_nxt == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr_q <= '0;
      else if (advance)
         ptr_q <= ptr_nxt;
   end

   assign ptr = ptr_q;

endmodule

// File: rtl/ssg_attn_flag.sv
module ssg_attn_flag #(
   parameter int SLACK = 0,
   parameter int SW    = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic entry_wr,
   input  logic hit,
   input  logic clr,
   output logic accept,
   output logic set_evt,
   output logic attn
);

   logic attn_q;
   logic room;

   generate
      if (SLACK == 0) begin : g_no_slack
         assign room = 1'b0;
      end else begin : g_slack
         logic [SW-1:0] slack_q;
         // counts writes taken after the flag rose; starts exhausted at reset
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               slack_q <= SW'(SLACK);
            else if (!attn_q)
               slack_q <= '0;
            else if (accept)
               slack_q <= slack_q + 1'b1;
         end
         assign room = (slack_q < SW'(SLACK));
      end
   endgenerate

   assign accept  = entry_wr & (~attn_q | room);
   assign set_evt = accept & hit;

   // set wins over a coincident clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         attn_q <= 1'b1;
      else
         attn_q <= set_evt | (attn_q & ~clr);
   end

   assign attn = attn_q;

endmodule

// File: rtl/status_slot_guard.sv
module status_slot_guard #(
   parameter int                  DEPTH    = 8,
   parameter ssg_pkg::ssg_variant_e VARIANT = ssg_pkg::SSG_RX,
   parameter int                  TX_SLACK = 2,
   parameter int                  PW       = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          limit_wr,
   input  logic [PW-1:0] limit_data,
   input  logic          entry_wr,
   input  logic          attn_clr,
   input  logic          usr_attn,
   output logic          attn,
   output logic          stall,
   output logic          last_tag,
   output logic [PW-1:0] wr_ptr
);

   localparam bit IS_RX     = (VARIANT == ssg_pkg::SSG_RX);
   localparam int SLACK_EFF = IS_RX ? 0 : TX_SLACK;
   localparam int SW        = (SLACK_EFF > 0) ? $clog2(SLACK_EFF + 1) : 1;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("status_slot_guard: DEPTH must be a power of two of at least 2");
      end
      if (PW != $clog2(DEPTH)) begin : g_bad_pw
         $error("status_slot_guard: PW must equal clog2(DEPTH)");
      end
      if (TX_SLACK < 0 || TX_SLACK >= DEPTH) begin : g_bad_slack
         $error("status_slot_guard: TX_SLACK must lie in 0..DEPTH-1");
      end
   endgenerate

   logic [PW-1:0] limit_w;
   logic          hit_w;
   logic          acc_w;
   logic          set_w;
   logic          attn_w;

   ssg_limit_reg #(.PW(PW)) u_limit (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (limit_wr),
      .load_val (limit_data),
      .limit    (limit_w)
   );

   ssg_wr_ptr #(.DEPTH(DEPTH), .PW(PW)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (acc_w),
      .limit   (limit_w),
      .ptr     (wr_ptr),
      .hit     (hit_w)
   );

   ssg_attn_flag #(.SLACK(SLACK_EFF), .SW(SW)) u_flag (
      .clk      (clk),
      .rst_n    (rst_n),
      .entry_wr (entry_wr),
      .hit      (hit_w),
      .clr      (attn_clr),
      .accept   (acc_w),
      .set_evt  (set_w),
      .attn     (attn_w)
   );

   assign attn = attn_w;

   generate
      if (IS_RX) begin : g_rx
         logic unused_usr;
         assign unused_usr = usr_attn;
         assign stall      = attn_w;
         assign last_tag   = set_w;
      end else begin : g_tx
         assign stall    = attn_w | usr_attn;
         assign last_tag = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/ssg_guard_checker.sv
module ssg_guard_checker #(
   parameter int DEPTH = 8,
   parameter int PW    = 3,
   parameter int SLACK = 0,
   parameter bit IS_RX = 1'b1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          entry_wr,
   input logic          attn_clr,
   input logic          usr_attn,
   input logic          attn,
   input logic          stall,
   input logic          last_tag,
   input logic [PW-1:0] wr_ptr,
   input logic          accept,
   input logic          hit
);

   function automatic logic [PW-1:0] step_idx(input logic [PW-1:0] k);
      return (k == PW'(DEPTH - 1)) ? '0 : k + 1'b1;
   endfunction

   int unsigned taken_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         taken_cnt <= 0;
      else if (!attn)
         taken_cnt <= 0;
      else if (accept)
         taken_cnt <= taken_cnt + 1;
   end

   assert_ptr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> wr_ptr == step_idx($past(wr_ptr)));

   assert_set_on_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && hit) |=> attn);

   assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (attn && !attn_clr) |=> attn);

   assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (attn && attn_clr && !(accept && hit)) |=> !attn);

   assert_set_beats_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (attn_clr && accept && hit) |=> attn);

   assert_rx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (IS_RX && attn && entry_wr) |=> $stable(wr_ptr));

   assert_attn_stalls_R6: assert property (@(posedge clk) disable iff (!rst_n)
      attn |-> stall);

   assert_tag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      last_tag |-> (IS_RX && entry_wr && !attn));

   assert_tag_then_attn_R7: assert property (@(posedge clk) disable iff (!rst_n)
      last_tag |=> attn);

   assert_slack_R8: assert property (@(posedge clk) disable iff (!rst_n)
      taken_cnt <= SLACK);

   assert_usr_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!IS_RX && usr_attn) |-> stall);

endmodule

bind status_slot_guard ssg_guard_checker #(
   .DEPTH (DEPTH),
   .PW    (PW),
   .SLACK (SLACK_EFF),
   .IS_RX (IS_RX)
) u_guard_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .entry_wr (entry_wr),
   .attn_clr (attn_clr),
   .usr_attn (usr_attn),
   .attn     (attn),
   .stall    (stall),
   .last_tag (last_tag),
   .wr_ptr   (wr_ptr),
   .accept   (acc_w),
   .hit      (hit_w)
);

// File: tb/status_slot_guard_test.sv
`timescale 1ns/1ps
module status_slot_guard_test;

   localparam int D  = 8;
   localparam int PW = 3;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic          rst_n;
   logic          limit_wr;
   logic [PW-1:0] limit_data;
   logic          entry_wr;
   logic          attn_clr;
   logic          usr_attn;

   logic          attn_r, stall_r, tag_r;
   logic [PW-1:0] ptr_r;
   logic          attn_t, stall_t, tag_t;
   logic [PW-1:0] ptr_t;

   status_slot_guard #(.DEPTH(D), .VARIANT(ssg_pkg::SSG_RX)) uut (
      .clk(clk), .rst_n(rst_n), .limit_wr(limit_wr), .limit_data(limit_data),
      .entry_wr(entry_wr), .attn_clr(attn_clr), .usr_attn(usr_attn),
      .attn(attn_r), .stall(stall_r), .last_tag(tag_r), .wr_ptr(ptr_r));

   status_slot_guard #(.DEPTH(D), .VARIANT(ssg_pkg::SSG_TX)) uut_tx (
      .clk(clk), .rst_n(rst_n), .limit_wr(limit_wr), .limit_data(limit_data),
      .entry_wr(entry_wr), .attn_clr(attn_clr), .usr_attn(usr_attn),
      .attn(attn_t), .stall(stall_t), .last_tag(tag_t), .wr_ptr(ptr_t));

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // reference state: index 0 receive, index 1 transmit
   int m_ptr[2];
   bit m_attn[2];
   int m_slack[2];
   int m_lim;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic check_regs();
      chk(int'(ptr_r) == m_ptr[0], "R2 R6 rx wr_ptr", int'(ptr_r), m_ptr[0]);
      chk(attn_r == m_attn[0], "R3 R4 R5 rx attn", attn_r, m_attn[0]);
      chk(int'(ptr_t) == m_ptr[1], "R2 R8 tx wr_ptr", int'(ptr_t), m_ptr[1]);
      chk(attn_t == m_attn[1], "R3 R4 R5 tx attn", attn_t, m_attn[1]);
   endtask

   // one clock: check registered state, drive, check combinational outputs, advance model
   task automatic cyc(input bit wr, input bit clr, input bit lw, input int ld, input bit usr);
      @(negedge clk);
      check_regs();
      entry_wr   = wr;
      attn_clr   = clr;
      limit_wr   = lw;
      limit_data = PW'(ld);
      usr_attn   = usr;
      #1;
      chk(stall_r == m_attn[0], "R6 rx stall", stall_r, m_attn[0]);
      chk(stall_t == (m_attn[1] | usr), "R9 tx stall", stall_t, m_attn[1] | usr);
      chk(tag_t == 1'b0, "R9 tx last_tag", tag_t, 0);
      for (int v = 0; v < 2; v++) begin
         int  s;
         bit  acc;
         bit  hit;
         s   = (v == 0) ? 0 : 2;
         acc = wr && (!m_attn[v] || m_slack[v] < s);
         hit = acc && (((m_ptr[v] + 1) % D) == m_lim);
         if (v == 0)
            chk(tag_r == hit, "R7 rx last_tag", tag_r, hit);
         if (acc) m_ptr[v] = (m_ptr[v] + 1) % D;
         if (!m_attn[v]) m_slack[v] = 0;
         else if (acc) m_slack[v] = m_slack[v] + 1;
         m_attn[v] = hit | (m_attn[v] & !clr);
      end
      if (lw) m_lim = ld % D;   // R10: takes effect after this cycle's compare
   endtask

   initial begin
      rst_n = 1'b0; limit_wr = 1'b0; limit_data = '0;
      entry_wr = 1'b0; attn_clr = 1'b0; usr_attn = 1'b0;
      for (int v = 0; v < 2; v++) begin
         m_ptr[v] = 0; m_attn[v] = 1'b1; m_slack[v] = (v == 0) ? 0 : 2;
      end
      m_lim = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(attn_r == 1'b1 && attn_t == 1'b1, "R1 attn after reset", attn_r & attn_t, 1);
      chk(stall_r == 1'b1 && stall_t == 1'b1, "R1 stall after reset", stall_r & stall_t, 1);
      chk(ptr_r == '0 && ptr_t == '0, "R1 wr_ptr after reset", int'(ptr_r | ptr_t), 0);
      chk(tag_r == 1'b0, "R1 last_tag after reset", tag_r, 0);

      // writes while still stalled from reset are dropped (R6, R8)
      repeat (3) cyc(1, 0, 0, 0, 0);

      // sweep every limit; write well past the trip point
      for (int lim = 0; lim < D; lim++) begin
         cyc(0, 0, 1, (lim + 3) % D, 0);   // R10 load
         cyc(0, 1, 0, 0, 1);               // clear, usr high on tx
         for (int k = 0; k < D + 3; k++)
            cyc(1, 0, 0, 0, (k % 3) == 0);
      end

      // clear held on every cycle: set must win when they coincide (R5)
      for (int lim = 0; lim < D; lim++) begin
         cyc(0, 1, 1, (lim * 5 + 1) % D, 0);
         for (int k = 0; k < D + 2; k++)
            cyc(1, 1, 0, 0, 0);
         cyc(0, 0, 0, 0, 0);
      end

      // mixed pattern: limit loads coinciding with writes, sparse clears
      for (int i = 0; i < 300; i++)
         cyc((i % 4) != 3, (i % 7) == 0, (i % 5) == 2, (i * 3 + 1) % D, (i % 6) < 2);

      @(negedge clk);
      check_regs();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 50000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual %0d expected %0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule